// File: doc/BRIEF.md
# Register-Programmed Display Timing Engine

This block produces the horizontal sync, vertical sync, data enable and pixel output of a display port from a small bank of word-addressed configuration registers. Horizontal positions are counted in pixel clocks inside one line. Vertical positions are not line numbers. They are absolute pixel-clock offsets from the first clock of the frame, so a vertical limit may also carry a horizontal skew. A second, narrower window marks where real pixels are carried. Inside the display window but outside that active window, the block drives a border color. During an underflow of the pixel source, it drives a programmed underflow color.

Software first programs the line period, the frame period, the sync widths and the windows. It then sets the enable bit. The engine can raise a one-clock fetch trigger at a programmed frame position, and it keeps a frame counter and a line counter that software can read back. Timing registers are held in shadow copies that load at frame boundaries, so a write made during a frame takes effect only at the start of the next frame.

Top module: `disp_timing_engine`

## Requirements
- R1: Registers are addressed by word index: 0 enable, 1 config, 2 line control (line period in bits 31:16, hsync width in bits 15:0), 3 frame period, 4 vsync width, 5 display horizontal window (end 31:16, start 15:0), 6 and 7 display vertical start and end, 8 active horizontal window (end 31:16, start 15:0), 9 and 10 active vertical start and end, 11 border color, 12 underflow color, 13 polarity, 14 count enable, 15 fetch position. Each of these reads back the value written to it. Index 16 reads the frame counter and index 17 reads the line counter. Writes to 16 and 17 are ignored.
- R2: While running, the line position counts from 0 to the line period minus 1 and then wraps. Hsync is active while the line position is below the hsync width.
- R3: While running, the frame position counts from 0 to the frame period minus 1 and then wraps. Vsync is active while the frame position is below the vsync width.
- R4: Data enable is active when the line position lies within the display horizontal start and end, and the frame position lies within the display vertical start and end. All four bounds are inclusive.
- R5: When data enable is active but the position lies outside an enabled active window, the pixel output is the border color. Config bit 29 enables the horizontal active limits and config bit 30 enables the vertical active limits.
- R6: Inside the active region the pixel output is the input pixel, or the underflow color while the underflow input is high. Whenever data enable is inactive, the pixel output is zero.
- R7: When config bit 31 is set, the fetch output pulses for one clock in each frame, in the cycle where the frame position equals the fetch register.
- R8: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable. A polarity write takes effect in the cycle after the write.
- R9: Bit 0 of the enable register starts the engine. In the first running cycle both positions are 0. When bit 0 is cleared, the sync and data enable outputs rest at their polarity-adjusted inactive level, the fetch output stays low, and the positions and counters return to zero one clock later.
- R10: With count-enable bit 0 set, the frame counter increments at each frame wrap. With count-enable bit 1 set, the line counter increments at each line wrap and clears at each frame wrap. Each counter holds its value while its bit is clear.
- R11: Registers 1 to 10 are shadowed. A write made while the engine runs takes effect in the first cycle of the next frame. While the engine is stopped, a write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | AW | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational register read data |
| pixIn | input | DW | Pixel from the source |
| pixUnderflow | input | 1 | Source has no pixel this cycle |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Data enable after polarity |
| pixOut | output | DW | Pixel, border or underflow color |
| fetchPulse | output | 1 | One-clock fetch trigger |

## Verification
The assertions assume a consistent programming. The line period is at least 1, and the frame period is a nonzero multiple of the line period and at least 2, so every frame wrap coincides with a line wrap and no two fetch pulses are adjacent. The stimulus programs a ten-clock line and a six-line frame while the engine is stopped. After that it changes only a display window, the polarity and the count enables, none of which affects the periods. The bench then sweeps every position of three whole frames and compares each output with values computed from the position arithmetic.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  localparam int REG_COUNT   = 16;
  localparam int A_ENABLE    = 0;
  localparam int A_CONFIG    = 1;
  localparam int A_HCTL      = 2;
  localparam int A_VPERIOD   = 3;
  localparam int A_VPULSE    = 4;
  localparam int A_DISP_H    = 5;
  localparam int A_DISP_VS   = 6;
  localparam int A_DISP_VE   = 7;
  localparam int A_ACT_H     = 8;
  localparam int A_ACT_VS    = 9;
  localparam int A_ACT_VE    = 10;
  localparam int A_BORDER    = 11;
  localparam int A_UFLOW     = 12;
  localparam int A_POLARITY  = 13;
  localparam int A_CNT_EN    = 14;
  localparam int A_FETCH     = 15;
  localparam int A_FRAME_CNT = 16;
  localparam int A_LINE_CNT  = 17;
  // registers that only change at a frame boundary while running
  localparam logic [REG_COUNT-1:0] SHADOW_MASK = 16'h07FE;

  typedef struct packed {
    logic running;
    logic lineEnd;
    logic frameEnd;
  } tgStrobe_t;
endpackage

// File: rtl/disp_timing_ctrl.sv
module disp_timing_ctrl
  import disp_timing_pkg::*;
#(
  parameter int FW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [HW-1:0] hPeriod,
  input  logic [FW-1:0] vPeriod,
  input  logic [1:0]    cntEn,
  output logic [HW-1:0] hPos,
  output logic [FW-1:0] fPos,
  output logic [FW-1:0] frameCnt,
  output logic [FW-1:0] lineCnt,
  output tgStrobe_t     strobe
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [FW-1:0] F_ONE = FW'(1);

  always_comb begin
    strobe.running  = enable;
    strobe.lineEnd  = enable && (hPos == hPeriod - H_ONE);
    strobe.frameEnd = enable && (fPos == vPeriod - F_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.running) begin
      hPos     <= '0;
      fPos     <= '0;
      frameCnt <= '0;
      lineCnt  <= '0;
    end else begin
      hPos <= strobe.lineEnd  ? '0 : hPos + H_ONE;
      fPos <= strobe.frameEnd ? '0 : fPos + F_ONE;
      if (cntEn[0] && strobe.frameEnd) frameCnt <= frameCnt + F_ONE;
      if (cntEn[1]) begin
        if (strobe.frameEnd)     lineCnt <= '0;
        else if (strobe.lineEnd) lineCnt <= lineCnt + F_ONE;
      end
    end
  end
endmodule

// File: rtl/disp_timing_dpath.sv
module disp_timing_dpath
  import disp_timing_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 5,
  parameter int FW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic [DW-1:0] pixIn,
  input  logic          pixUnderflow,
  input  logic [HW-1:0] hPos,
  input  logic [FW-1:0] fPos,
  input  logic [FW-1:0] frameCnt,
  input  logic [FW-1:0] lineCnt,
  input  tgStrobe_t     strobe,
  output logic          enable,
  output logic [HW-1:0] hPeriod,
  output logic [FW-1:0] vPeriod,
  output logic [1:0]    cntEn,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic [DW-1:0] pixOut,
  output logic          fetchPulse
);
  localparam int RIDX = $clog2(REG_COUNT);

  logic [31:0] regFile [REG_COUNT];
  logic [31:0] shadow  [REG_COUNT];
  logic loadShadow, writeHit;
  logic hsRaw, vsRaw, deRaw, inActH, inActV, inAct;
  logic [2:0] pol;

  function automatic logic inWin(input logic [FW-1:0] p, input logic [FW-1:0] lo,
                                 input logic [FW-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  assign writeHit   = regWe && (int'(regAddr) < REG_COUNT);
  assign enable     = regFile[A_ENABLE][0];
  assign loadShadow = !enable || strobe.frameEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (writeHit) begin
      regFile[regAddr[RIDX-1:0]] <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rst || !SHADOW_MASK[i]) shadow[i] <= '0;
      else if (loadShadow)        shadow[i] <= regFile[i];
    end
  end

  assign hPeriod = shadow[A_HCTL][31:16];
  assign vPeriod = shadow[A_VPERIOD][FW-1:0];
  assign cntEn   = regFile[A_CNT_EN][1:0];
  assign pol     = regFile[A_POLARITY][2:0];

  always_comb begin
    hsRaw  = strobe.running && (hPos < shadow[A_HCTL][HW-1:0]);
    vsRaw  = strobe.running && (fPos < shadow[A_VPULSE][FW-1:0]);
    deRaw  = strobe.running
          && inWin(FW'(hPos), FW'(shadow[A_DISP_H][15:0]), FW'(shadow[A_DISP_H][31:16]))
          && inWin(fPos, shadow[A_DISP_VS][FW-1:0], shadow[A_DISP_VE][FW-1:0]);
    inActH = !shadow[A_CONFIG][29]
          || inWin(FW'(hPos), FW'(shadow[A_ACT_H][15:0]), FW'(shadow[A_ACT_H][31:16]));
    inActV = !shadow[A_CONFIG][30]
          || inWin(fPos, shadow[A_ACT_VS][FW-1:0], shadow[A_ACT_VE][FW-1:0]);
    inAct  = inActH && inActV;

    if (!deRaw)            pixOut = '0;
    else if (!inAct)       pixOut = regFile[A_BORDER][DW-1:0];
    else if (pixUnderflow) pixOut = regFile[A_UFLOW][DW-1:0];
    else                   pixOut = pixIn;

    hsyncOut   = hsRaw ^ pol[0];
    vsyncOut   = vsRaw ^ pol[1];
    deOut      = deRaw ^ pol[2];
    fetchPulse = strobe.running && regFile[A_CONFIG][31]
              && (fPos == regFile[A_FETCH][FW-1:0]);
  end

  always_comb begin
    if (int'(regAddr) == A_FRAME_CNT)     regRdata = 32'(frameCnt);
    else if (int'(regAddr) == A_LINE_CNT) regRdata = 32'(lineCnt);
    else if (int'(regAddr) < REG_COUNT)   regRdata = regFile[regAddr[RIDX-1:0]];
    else                                  regRdata = '0;
  end
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
  import disp_timing_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 5,
  parameter int FW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic [DW-1:0] pixIn,
  input  logic          pixUnderflow,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic [DW-1:0] pixOut,
  output logic          fetchPulse
);
  tgStrobe_t     strobe;
  logic          enable;
  logic [HW-1:0] hPeriod, hPos;
  logic [FW-1:0] vPeriod, fPos, frameCnt, lineCnt;
  logic [1:0]    cntEn;

  disp_timing_ctrl #(.FW(FW), .HW(HW)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .hPeriod(hPeriod), .vPeriod(vPeriod),
    .cntEn(cntEn), .hPos(hPos), .fPos(fPos), .frameCnt(frameCnt),
    .lineCnt(lineCnt), .strobe(strobe)
  );

  disp_timing_dpath #(.DW(DW), .AW(AW), .FW(FW), .HW(HW)) u_dpath (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pixIn(pixIn), .pixUnderflow(pixUnderflow),
    .hPos(hPos), .fPos(fPos), .frameCnt(frameCnt), .lineCnt(lineCnt),
    .strobe(strobe), .enable(enable), .hPeriod(hPeriod), .vPeriod(vPeriod),
    .cntEn(cntEn), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixOut(pixOut), .fetchPulse(fetchPulse)
  );
endmodule

// File: rtl/disp_timing_chk.sv
module disp_timing_chk
  import disp_timing_pkg::*;
#(
  parameter int FW = 32,
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst,
  input tgStrobe_t     strobe,
  input logic [HW-1:0] hPos,
  input logic [FW-1:0] fPos,
  input logic          fetchPulse
);
  // R2: a line wrap restarts the line position
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
    strobe.lineEnd |=> (hPos == '0));

  // R3: a frame wrap restarts the frame position
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    strobe.frameEnd |=> (fPos == '0));

  // R3: frame and line boundaries stay aligned
  a_r3_frame_on_line: assert property (@(posedge clk) disable iff (rst)
    strobe.frameEnd |-> strobe.lineEnd);

  // R7: the fetch trigger never lasts two cycles
  a_r7_fetch_single: assert property (@(posedge clk) disable iff (rst)
    fetchPulse |=> !fetchPulse);

  // R9: a stopped engine keeps its positions at zero and no fetch
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!strobe.running && $past(!strobe.running)) |-> (hPos == '0 && fPos == '0 && !fetchPulse));
endmodule

bind disp_timing_engine disp_timing_chk #(.FW(FW), .HW(HW)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .hPos(hPos), .fPos(fPos),
  .fetchPulse(fetchPulse)
);

// File: tb/tb_disp_timing_engine.sv
module tb_disp_timing_engine;
  localparam int DW = 24;
  localparam logic [31:0] BORDER = 32'h00_AA55CC;
  localparam logic [31:0] UFC    = 32'h00_123456;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [DW-1:0] pixIn = '0;
  logic pixUnderflow = 1'b0;
  logic hsyncOut, vsyncOut, deOut, fetchPulse;
  logic [DW-1:0] pixOut;
  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  disp_timing_engine dut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pixIn(pixIn), .pixUnderflow(pixUnderflow),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixOut(pixOut),
    .fetchPulse(fetchPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    regAddr = 5'd16;
    #4;
    chk("R9 reset hsync", 32'(hsyncOut), 0);
    chk("R9 reset vsync", 32'(vsyncOut), 0);
    chk("R9 reset de", 32'(deOut), 0);
    chk("R9 reset fetch", 32'(fetchPulse), 0);
    chk("R10 reset frame count", regRdata, 0);
    @(posedge clk); #1;

    wr(5'd2, {16'd10, 16'd2});
    wr(5'd3, 32'd60);
    wr(5'd4, 32'd10);
    wr(5'd5, {16'd8, 16'd4});
    wr(5'd6, 32'd20);
    wr(5'd7, 32'd49);
    wr(5'd8, {16'd7, 16'd5});
    wr(5'd9, 32'd30);
    wr(5'd10, 32'd39);
    wr(5'd11, BORDER);
    wr(5'd12, UFC);
    wr(5'd13, 32'd0);
    wr(5'd14, 32'd3);
    wr(5'd15, 32'd55);
    wr(5'd1, 32'hE000_0000);
    regAddr = 5'd11;
    #4 chk("R1 readback border", regRdata, BORDER);
    @(posedge clk); #1;
    wr(5'd0, 32'd1);

    for (int k = 0; k < 180; k++) begin
      int h, f, fr, dhs, dhe, lineExp;
      logic de, act, uf;
      logic [2:0] pol;
      logic [DW-1:0] pexp;
      pixIn = DW'(k * 3 + 1);
      uf = (k % 7 == 3);
      pixUnderflow = uf;
      if (k == 30) begin
        regWe = 1'b1; regAddr = 5'd5; regWdata = {16'd6, 16'd5};
      end else if (k == 119) begin
        regWe = 1'b1; regAddr = 5'd13; regWdata = 32'd5;
      end else if (k == 150) begin
        regWe = 1'b1; regAddr = 5'd14; regWdata = 32'd1;
      end else begin
        regWe = 1'b0; regAddr = 5'd17;
      end
      #4;
      h = k % 10; f = k % 60; fr = k / 60;
      dhs = (fr >= 1) ? 5 : 4;
      dhe = (fr >= 1) ? 6 : 8;
      de  = (h >= dhs) && (h <= dhe) && (f >= 20) && (f <= 49);
      act = (h >= 5) && (h <= 7) && (f >= 30) && (f <= 39);
      pol = (k >= 120) ? 3'b101 : 3'b000;
      if (!de)      pexp = '0;
      else if (!act) pexp = BORDER[DW-1:0];
      else if (uf)  pexp = UFC[DW-1:0];
      else          pexp = DW'(k * 3 + 1);
      chk("R2/R8 hsync", 32'(hsyncOut), 32'((h < 2) ^ pol[0]));
      chk("R3/R8 vsync", 32'(vsyncOut), 32'((f < 10) ^ pol[1]));
      chk("R4/R11/R8 data enable", 32'(deOut), 32'(de ^ pol[2]));
      chk("R5/R6 pixel", 32'(pixOut), 32'(pexp));
      chk("R7 fetch", 32'(fetchPulse), 32'(f == 55));
      lineExp = (k >= 151) ? 3 : f / 10;
      if (!regWe) chk("R10 line count", regRdata, 32'(lineExp));
      @(posedge clk); #1;
    end
    regWe = 1'b0;
    regAddr = 5'd16;
    #4 chk("R10 frame count", regRdata, 32'd3);
    @(posedge clk); #1;
    wr(5'd16, 32'hDEAD);
    regAddr = 5'd16;
    #4 chk("R1 counter write ignored", regRdata, 32'd3);
    @(posedge clk); #1;

    wr(5'd0, 32'd0);
    regAddr = 5'd16;
    #4;
    chk("R9 idle hsync level", 32'(hsyncOut), 1);
    chk("R9 idle vsync level", 32'(vsyncOut), 0);
    chk("R9 idle de level", 32'(deOut), 1);
    chk("R9 idle fetch", 32'(fetchPulse), 0);
    chk("R9 idle pixel", 32'(pixOut), 0);
    @(posedge clk); #1;
    #4 chk("R9 counters cleared", regRdata, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule